// File: doc/BRIEF.md
# Walking-Zero Link Test Generator and Checker

This block exercises a parallel data link between two processing nodes and looks for wiring faults. Open lines, lines shorted together, and lines disturbed by ground bounce or crosstalk all show up. The generator half drives a fixed test sequence onto the link. It alternates an all-zeros word with a word that has a single zero walking through an all-ones background. The checker half sits at the far end of the link and builds its own copy of the same sequence. It compares every word it receives against that copy.

The first mismatch is latched. The checker stores the word it received, the word it expected and that word's position in the sequence. It also presents a fixed checker identifier, so a failure report names the link it came from. Pass, fail and done flags summarise the run. A single start strobe begins a new run on both halves and clears the previous result. The check covers only the wiring and the path between nodes. It does not cover the logic inside the devices at either end.

Top module: `link_test_top`

## Requirements
- R1: The sequence has NWORDS = 2*WIDTH words indexed from 0. A word with an odd index is all zeros. A word with an even index i is all ones except bit i/2, which is 0.
- R2: A start strobe makes `gen_valid_o` high from the next cycle for exactly NWORDS consecutive cycles, driving the words in index order; then it goes low. A start during a run restarts at index 0.
- R3: The checker consumes one word on each cycle with `chk_valid_i` high while a run is active. Cycles with `chk_valid_i` low do not advance the expected index.
- R4: On the first mismatching word, the checker latches the received word, the expected word and the index. Later mismatches in the same run leave the captured values unchanged.
- R5: `fail_o` is sticky. Only reset or a start strobe clears it. A start strobe also clears `done_o` and the captured values to zero and restarts the expected index at 0. A `chk_valid_i` in the same cycle as start is ignored.
- R6: `done_o` rises in the cycle after the NWORDS-th word is consumed and not before. `pass_o` is high exactly when `done_o` is high and `fail_o` is low.
- R7: `chk_id_o` always shows the CHECKER_ID parameter.
- R8: Words that arrive after `done_o` is high are ignored until the next start strobe.
- R9: After reset, `gen_valid_o`, `gen_data_o`, `pass_o`, `fail_o`, `done_o` and all capture outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe for both generator and checker |
| gen_data_o | output | WIDTH | Test word driven onto the link |
| gen_valid_o | output | 1 | Generator word valid |
| chk_data_i | input | WIDTH | Word received from the link |
| chk_valid_i | input | 1 | Received word valid |
| pass_o | output | 1 | Run finished without mismatch |
| fail_o | output | 1 | Sticky mismatch flag |
| done_o | output | 1 | All NWORDS words consumed |
| err_data_o | output | WIDTH | Received word at the first mismatch |
| err_exp_o | output | WIDTH | Expected word at the first mismatch |
| err_idx_o | output | IDX_W | Sequence index of the first mismatch |
| chk_id_o | output | ID_W | Fixed checker identifier |

## Verification
The bench runs clean loopback runs and clean runs with random gaps in valid. These show that the pattern matches and that idle cycles do not shift the expected index. It then injects single stuck-at-1 and stuck-at-0 lines, and wired-AND and wired-OR shorts between random line pairs. Each fault model first differs from the sequence at a different index, so the captured index and words show that the correct first mismatch was latched and that later ones were ignored. Directed cases cover a start during a run, data arriving after done, and the clearing of a sticky failure by a new start.

// File: rtl/link_test_pkg.sv
package link_test_pkg;
  typedef enum logic [1:0] {
    CHK_IDLE = 2'd0,
    CHK_RUN  = 2'd1,
    CHK_DONE = 2'd2
  } chk_state_e;
endpackage

// File: rtl/wz_pattern.sv
module wz_pattern #(
  parameter int WIDTH = 32,
  parameter int IDX_W = $clog2(2 * WIDTH)
) (
  input  logic [IDX_W-1:0] idx_i,
  output logic [WIDTH-1:0] word_o
);
  always_comb begin
    word_o = '0;
    if (!idx_i[0]) begin
      word_o = '1;
      word_o[idx_i[IDX_W-1:1]] = 1'b0;
    end
  end
endmodule

// File: rtl/wz_gen.sv
module wz_gen #(
  parameter int WIDTH  = 32,
  parameter int IDX_W  = $clog2(2 * WIDTH),
  parameter int NWORDS = 2 * WIDTH
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output logic [WIDTH-1:0] data_o,
  output logic             valid_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NWORDS - 1);

  logic             active_q;
  logic [IDX_W-1:0] idx_q;
  logic [WIDTH-1:0] pat;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      idx_q    <= '0;
    end else if (start_i) begin
      active_q <= 1'b1;
      idx_q    <= '0;
    end else if (active_q) begin
      if (idx_q == LAST) begin
        active_q <= 1'b0;
        idx_q    <= '0;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  wz_pattern #(.WIDTH(WIDTH), .IDX_W(IDX_W)) u_pat (.idx_i(idx_q), .word_o(pat));

  assign data_o  = active_q ? pat : '0;
  assign valid_o = active_q;
endmodule

// File: rtl/wz_chk.sv
module wz_chk
  import link_test_pkg::*;
#(
  parameter int WIDTH  = 32,
  parameter int IDX_W  = $clog2(2 * WIDTH),
  parameter int NWORDS = 2 * WIDTH
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic             valid_i,
  output logic             fail_o,
  output logic             done_o,
  output logic [WIDTH-1:0] err_data_o,
  output logic [WIDTH-1:0] err_exp_o,
  output logic [IDX_W-1:0] err_idx_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NWORDS - 1);

  chk_state_e       st_q;
  logic [IDX_W-1:0] cnt_q;
  logic             fail_q;
  logic [WIDTH-1:0] err_data_q, err_exp_q;
  logic [IDX_W-1:0] err_idx_q;
  logic [WIDTH-1:0] exp_word;
  logic             take, mismatch;

  wz_pattern #(.WIDTH(WIDTH), .IDX_W(IDX_W)) u_pat (.idx_i(cnt_q), .word_o(exp_word));

  assign take     = (st_q == CHK_RUN) && valid_i && !start_i;
  assign mismatch = data_i != exp_word;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= CHK_IDLE;
      cnt_q      <= '0;
      fail_q     <= 1'b0;
      err_data_q <= '0;
      err_exp_q  <= '0;
      err_idx_q  <= '0;
    end else if (start_i) begin
      st_q       <= CHK_RUN;
      cnt_q      <= '0;
      fail_q     <= 1'b0;
      err_data_q <= '0;
      err_exp_q  <= '0;
      err_idx_q  <= '0;
    end else if (take) begin
      // only the first mismatch of a run is latched
      if (mismatch && !fail_q) begin
        fail_q     <= 1'b1;
        err_data_q <= data_i;
        err_exp_q  <= exp_word;
        err_idx_q  <= cnt_q;
      end
      if (cnt_q == LAST) begin
        st_q  <= CHK_DONE;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign fail_o     = fail_q;
  assign done_o     = st_q == CHK_DONE;
  assign err_data_o = err_data_q;
  assign err_exp_o  = err_exp_q;
  assign err_idx_o  = err_idx_q;
endmodule

// File: rtl/link_test_top.sv
module link_test_top #(
  parameter int              WIDTH      = 32,
  parameter int              ID_W       = 8,
  parameter logic [ID_W-1:0] CHECKER_ID = 8'hA5,
  localparam int             NWORDS     = 2 * WIDTH,
  localparam int             IDX_W      = $clog2(NWORDS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output logic [WIDTH-1:0] gen_data_o,
  output logic             gen_valid_o,
  input  logic [WIDTH-1:0] chk_data_i,
  input  logic             chk_valid_i,
  output logic             pass_o,
  output logic             fail_o,
  output logic             done_o,
  output logic [WIDTH-1:0] err_data_o,
  output logic [WIDTH-1:0] err_exp_o,
  output logic [IDX_W-1:0] err_idx_o,
  output logic [ID_W-1:0]  chk_id_o
);
  wz_gen #(.WIDTH(WIDTH), .IDX_W(IDX_W), .NWORDS(NWORDS)) u_gen (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .data_o  (gen_data_o),
    .valid_o (gen_valid_o)
  );

  wz_chk #(.WIDTH(WIDTH), .IDX_W(IDX_W), .NWORDS(NWORDS)) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .data_i     (chk_data_i),
    .valid_i    (chk_valid_i),
    .fail_o     (fail_o),
    .done_o     (done_o),
    .err_data_o (err_data_o),
    .err_exp_o  (err_exp_o),
    .err_idx_o  (err_idx_o)
  );

  assign pass_o   = done_o && !fail_o;
  assign chk_id_o = CHECKER_ID;
endmodule

// File: rtl/link_test_sva.sv
module link_test_sva #(
  parameter int WIDTH = 32,
  parameter int IDX_W = 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic [WIDTH-1:0] gen_data_o,
  input logic             gen_valid_o,
  input logic             pass_o,
  input logic             fail_o,
  input logic             done_o,
  input logic [WIDTH-1:0] err_data_o,
  input logic [WIDTH-1:0] err_exp_o,
  input logic [IDX_W-1:0] err_idx_o
);
  p_word_shape_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gen_valid_o |-> (gen_data_o == '0) || ($countones(gen_data_o) == WIDTH - 1));

  p_fail_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o && !start_i |=> fail_o);

  p_start_clears_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !fail_o && !done_o);

  p_capture_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o && !start_i |=> $stable(err_data_o) && $stable(err_exp_o) && $stable(err_idx_o));

  p_mismatch_real_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |-> err_data_o != err_exp_o);

  p_pass_excl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pass_o |-> done_o && !fail_o);

  p_done_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !start_i |=> done_o);
endmodule

bind link_test_top link_test_sva #(.WIDTH(WIDTH), .IDX_W(IDX_W)) u_sva (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .gen_data_o  (gen_data_o),
  .gen_valid_o (gen_valid_o),
  .pass_o      (pass_o),
  .fail_o      (fail_o),
  .done_o      (done_o),
  .err_data_o  (err_data_o),
  .err_exp_o   (err_exp_o),
  .err_idx_o   (err_idx_o)
);

// File: tb/tb_link_test_top.sv
`timescale 1ns/1ps
module tb_link_test_top;
  localparam int              WIDTH  = 32;
  localparam int              ID_W   = 8;
  localparam logic [ID_W-1:0] CID    = 8'h3C;
  localparam int              NWORDS = 2 * WIDTH;
  localparam int              IDX_W  = $clog2(NWORDS);

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [WIDTH-1:0] gen_data, chk_data, drv_data = '0;
  logic gen_valid, chk_valid, drv_valid = 1'b0, loop_en = 1'b0;
  logic pass, fail, done;
  logic [WIDTH-1:0] err_data, err_exp;
  logic [IDX_W-1:0] err_idx;
  logic [ID_W-1:0]  chk_id;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  assign chk_data  = loop_en ? gen_data  : drv_data;
  assign chk_valid = loop_en ? gen_valid : drv_valid;

  link_test_top #(.WIDTH(WIDTH), .ID_W(ID_W), .CHECKER_ID(CID)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .gen_data_o(gen_data), .gen_valid_o(gen_valid),
    .chk_data_i(chk_data), .chk_valid_i(chk_valid),
    .pass_o(pass), .fail_o(fail), .done_o(done),
    .err_data_o(err_data), .err_exp_o(err_exp), .err_idx_o(err_idx),
    .chk_id_o(chk_id)
  );

  function automatic logic [WIDTH-1:0] exp_word(int i);
    logic [WIDTH-1:0] w;
    if (i % 2 == 1) return '0;
    w = '1;
    w[i/2] = 1'b0;
    return w;
  endfunction

  // kind: 0 none, 1 stuck-1 a, 2 stuck-0 a, 3 wired-AND a,b, 4 wired-OR a,b
  function automatic logic [WIDTH-1:0] fault(logic [WIDTH-1:0] w, int kind, int a, int b);
    logic [WIDTH-1:0] r = w;
    case (kind)
      1: r[a] = 1'b1;
      2: r[a] = 1'b0;
      3: begin r[a] = w[a] & w[b]; r[b] = w[a] & w[b]; end
      4: begin r[a] = w[a] | w[b]; r[b] = w[a] | w[b]; end
      default: ;
    endcase
    return r;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic send(logic [WIDTH-1:0] w);
    drv_data = w; drv_valid = 1'b1;
    @(negedge clk); drv_valid = 1'b0;
  endtask

  task automatic run_fault(int kind, int a, int b, string req);
    int first = -1;
    logic [WIDTH-1:0] fw = '0;
    logic [WIDTH-1:0] fe = '0;
    pulse_start();
    for (int i = 0; i < NWORDS; i++) begin
      if ($urandom % 3 == 0) @(negedge clk);
      if (first < 0 && fault(exp_word(i), kind, a, b) != exp_word(i)) begin
        first = i; fw = fault(exp_word(i), kind, a, b); fe = exp_word(i);
      end
      send(fault(exp_word(i), kind, a, b));
    end
    check({req, " done"}, 64'(done), 64'(1));
    check({req, " fail"}, 64'(fail), 64'(first >= 0));
    check({req, " pass"}, 64'(pass), 64'(first < 0));
    if (first >= 0) begin
      check({req, " err_idx"}, 64'(err_idx), 64'(first));
      check({req, " err_data"}, 64'(err_data), 64'(fw));
      check({req, " err_exp"}, 64'(err_exp), 64'(fe));
      check("R7 id with failure", 64'(chk_id), 64'(CID));
    end
  endtask

  initial begin
    #(200000 * 20);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    // R9 reset state
    #1;
    check("R9 gen_valid", 64'(gen_valid), 0);
    check("R9 gen_data", 64'(gen_data), 0);
    check("R9 flags", {61'd0, pass, fail, done}, 0);
    check("R9 capture", 64'(err_data) | 64'(err_exp) | 64'(err_idx), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 R2 generator sequence and length
    pulse_start();
    for (int i = 0; i < NWORDS; i++) begin
      check("R2 gen_valid", 64'(gen_valid), 1);
      check("R1 word", 64'(gen_data), 64'(exp_word(i)));
      @(negedge clk);
    end
    check("R2 valid low after run", 64'(gen_valid), 0);

    // R2 restart during a run
    pulse_start();
    repeat (5) @(negedge clk);
    pulse_start();
    check("R2 restart word0", 64'(gen_data), 64'(exp_word(0)));
    repeat (NWORDS - 1) @(negedge clk);
    check("R2 restart last valid", 64'(gen_valid), 1);
    @(negedge clk);
    check("R2 restart end", 64'(gen_valid), 0);

    // R6 clean loopback
    loop_en = 1'b1;
    pulse_start();
    repeat (NWORDS + 2) @(negedge clk);
    check("R6 loopback pass", {62'd0, pass, fail}, 64'b10);
    loop_en = 1'b0;

    // R3 R6 clean run with gaps, done timing
    pulse_start();
    repeat (4) @(negedge clk);
    for (int i = 0; i < NWORDS; i++) begin
      if ($urandom % 2 == 0) repeat (1 + $urandom % 3) @(negedge clk);
      if (i == NWORDS - 1) check("R6 no early done", 64'(done), 0);
      send(exp_word(i));
    end
    check("R3 gaps pass", 64'(pass), 1);
    check("R6 done", 64'(done), 1);
    check("R7 id", 64'(chk_id), 64'(CID));

    // R8 late word ignored
    send(32'h1234_5678);
    check("R8 fail after done", 64'(fail), 0);
    check("R8 pass holds", 64'(pass), 1);

    // R4 directed and random faults
    run_fault(1, 0, 0, "R4 stuck1 b0");
    run_fault(2, 0, 0, "R4 stuck0 b0");
    run_fault(2, WIDTH - 1, 0, "R4 stuck0 msb");
    for (int k = 0; k < 6; k++) begin
      int a = $urandom % WIDTH;
      int b = (a + 1 + $urandom % (WIDTH - 1)) % WIDTH;
      run_fault(1 + k % 4, a, b, "R4 random");
    end

    // R5 sticky and cleared by start
    repeat (3) @(negedge clk);
    check("R5 sticky", 64'(fail), 1);
    drv_data = 32'hDEAD_BEEF; drv_valid = 1'b1;   // valid during start ignored
    pulse_start();
    drv_valid = 1'b0;
    check("R5 fail cleared", 64'(fail), 0);
    check("R5 done cleared", 64'(done), 0);
    check("R5 capture cleared", 64'(err_data) | 64'(err_idx), 0);
    send(exp_word(0));
    check("R5 index restarted", 64'(fail), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule